// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a compact processor that completes one instruction on every clock edge. Each instruction is a fixed 32-bit word. It is fetched from an internal word-organised program store and decoded. Two general registers are read from a 32-entry file, an arithmetic or logic result is formed, and the data store is read or written if the instruction needs it. The result is written back and the next program counter is chosen, all in the same cycle. Arithmetic only works on registers. Memory is reached through explicit load and store instructions that add a signed byte offset to a base register.

Both internal stores are filled through a plain load port. While `ld_en` is high, the core is frozen: the program counter holds and no register or store write from execution takes effect. Every word presented on the port is accepted on the next clock edge, so the port has no back-pressure. When `ld_en` drops, execution starts from the current program counter, which reset sets to 0.

Two output groups show every architectural effect as it happens. A write-back group shows each register write, and a store group shows each data-store write. Both are valid in the cycle before the clock edge that commits them.

Top module: `scpu_core`

## Requirements
- R1: On reset the program counter is 0 and all 32 registers read as 0.
- R2: Register-format words (op 0, shamt 0) with funct 32 (add) or 34 (sub) write rs+rt or rs-rt to rd. The fields are op[31:26], rs[25:21], rt[20:16], rd[15:11], shamt[10:6], funct[5:0].
- R3: addi (op 8) writes rs plus the sign-extended 16-bit immediate to rt. andi (op 12) and ori (op 13) combine rs with the zero-extended immediate and write the result to rt.
- R4: lui (op 15) writes {imm, 16'h0} to rt. A following ori on the same register fills in the low half, which builds any 32-bit constant.
- R5: slt (funct 42) and slti (op 10) write 1 when the first operand is less than the second as signed values, and 0 otherwise.
- R6: lw (op 35) writes the data word at byte address rs+sext(imm) to rt. sw (op 43) writes rt to that address and shows the address and data on the store outputs.
- R7: beq (op 4) and bne (op 5) go to PC+4+(sext(imm)<<2) when rs equals (beq) or differs from (bne) rt. Otherwise they go to PC+4.
- R8: j (op 2) goes to {PC+4[31:28], idx26, 2'b00}.
- R9: Register 0 always reads 0. A write aimed at it is dropped and raises no write-back strobe.
- R10: Any other encoding, including a register-format word with nonzero shamt or an unlisted funct, writes nothing and advances the PC by 4.
- R11: While `ld_en` is high the PC holds, `wb_en` and `st_en` stay low, and `ld_data` is written to word `ld_addr` of the data store (`ld_dmem`=1) or the program store (`ld_dmem`=0).
- R12: Address bits [1:0] do not select the word. A load or store whose address has nonzero low bits acts on the word that contains that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of PC and registers |
| ld_en | input | 1 | Load port enable; freezes execution |
| ld_dmem | input | 1 | Load target: 1 data store, 0 program store |
| ld_addr | input | LOAD_AW (8) | Word index for the load port |
| ld_data | input | 32 | Word written through the load port |
| pc_o | output | 32 | Address of the instruction now executing |
| wb_en | output | 1 | A register write commits at the next edge |
| wb_reg | output | 5 | Destination register of that write |
| wb_data | output | 32 | Value written |
| st_en | output | 1 | A data-store write commits at the next edge |
| st_addr | output | 32 | Byte address of the store |
| st_data | output | 32 | Word stored |

## Verification
A register that holds a wrong value shows up on `wb_data` or `st_data` in the same cycle that any later instruction reads it. If that value feeds a branch, it also shows up on `pc_o` one cycle later. A wrong program counter appears on `pc_o` one edge after the faulty update. Every cycle is compared against an instruction-level model, so a wrong internal state is caught within one to a few instructions of its first use.

// File: rtl/scpu_pkg.sv
package scpu_pkg;
  localparam int XLEN   = 32;
  localparam int NREG   = 32;
  localparam int REG_AW = $clog2(NREG);

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_J     = 6'd2;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_BNE   = 6'd5;
  localparam logic [5:0] OP_ADDI  = 6'd8;
  localparam logic [5:0] OP_SLTI  = 6'd10;
  localparam logic [5:0] OP_ANDI  = 6'd12;
  localparam logic [5:0] OP_ORI   = 6'd13;
  localparam logic [5:0] OP_LUI   = 6'd15;
  localparam logic [5:0] OP_LW    = 6'd35;
  localparam logic [5:0] OP_SW    = 6'd43;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_SLT, ALU_AND, ALU_OR, ALU_PASSB
  } alu_op_e;

  typedef enum logic [1:0] {
    IMM_SEXT, IMM_ZEXT, IMM_UPPER
  } imm_kind_e;

  typedef struct packed {
    logic      reg_write;
    logic      dst_rd;
    logic      use_imm;
    imm_kind_e imm_kind;
    alu_op_e   alu_op;
    logic      mem_read;
    logic      mem_write;
    logic      br_eq;
    logic      br_ne;
    logic      jump;
  } ctrl_t;
endpackage

// File: rtl/scpu_decode.sv
module scpu_decode
  import scpu_pkg::*;
(
  input  logic [XLEN-1:0]   instr,
  output ctrl_t             ctl,
  output logic [REG_AW-1:0] rs,
  output logic [REG_AW-1:0] rt,
  output logic [REG_AW-1:0] rd,
  output logic [15:0]       imm16,
  output logic [XLEN-1:0]   imm_ext,
  output logic [25:0]       jidx
);
  logic [5:0] op;
  logic [5:0] funct;
  logic [4:0] shamt;

  assign op    = instr[31:26];
  assign rs    = instr[25:21];
  assign rt    = instr[20:16];
  assign rd    = instr[15:11];
  assign shamt = instr[10:6];
  assign funct = instr[5:0];
  assign imm16 = instr[15:0];
  assign jidx  = instr[25:0];

  always_comb begin
    ctl = '0;
    unique case (op)
      OP_RTYPE: begin
        if (shamt == 5'd0) begin
          unique case (funct)
            FN_ADD: begin ctl.reg_write = 1'b1; ctl.dst_rd = 1'b1; ctl.alu_op = ALU_ADD; end
            FN_SUB: begin ctl.reg_write = 1'b1; ctl.dst_rd = 1'b1; ctl.alu_op = ALU_SUB; end
            FN_SLT: begin ctl.reg_write = 1'b1; ctl.dst_rd = 1'b1; ctl.alu_op = ALU_SLT; end
            default: ;
          endcase
        end
      end
      OP_ADDI: begin ctl.reg_write = 1'b1; ctl.use_imm = 1'b1; ctl.imm_kind = IMM_SEXT; ctl.alu_op = ALU_ADD; end
      OP_SLTI: begin ctl.reg_write = 1'b1; ctl.use_imm = 1'b1; ctl.imm_kind = IMM_SEXT; ctl.alu_op = ALU_SLT; end
      OP_ANDI: begin ctl.reg_write = 1'b1; ctl.use_imm = 1'b1; ctl.imm_kind = IMM_ZEXT; ctl.alu_op = ALU_AND; end
      OP_ORI:  begin ctl.reg_write = 1'b1; ctl.use_imm = 1'b1; ctl.imm_kind = IMM_ZEXT; ctl.alu_op = ALU_OR; end
      OP_LUI:  begin ctl.reg_write = 1'b1; ctl.use_imm = 1'b1; ctl.imm_kind = IMM_UPPER; ctl.alu_op = ALU_PASSB; end
      OP_LW: begin
        ctl.reg_write = 1'b1; ctl.use_imm = 1'b1; ctl.imm_kind = IMM_SEXT;
        ctl.alu_op = ALU_ADD; ctl.mem_read = 1'b1;
      end
      OP_SW: begin
        ctl.use_imm = 1'b1; ctl.imm_kind = IMM_SEXT;
        ctl.alu_op = ALU_ADD; ctl.mem_write = 1'b1;
      end
      OP_BEQ: ctl.br_eq = 1'b1;
      OP_BNE: ctl.br_ne = 1'b1;
      OP_J:   ctl.jump  = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    unique case (ctl.imm_kind)
      IMM_ZEXT:  imm_ext = {16'h0000, imm16};
      IMM_UPPER: imm_ext = {imm16, 16'h0000};
      default:   imm_ext = {{16{imm16[15]}}, imm16};
    endcase
  end
endmodule

// File: rtl/scpu_regfile.sv
module scpu_regfile
  import scpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] wa,
  input  logic [XLEN-1:0]   wd,
  input  logic [REG_AW-1:0] ra1,
  input  logic [REG_AW-1:0] ra2,
  output logic [XLEN-1:0]   rd1,
  output logic [XLEN-1:0]   rd2
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

  // Entry 0 never takes a value, whatever the write port does.
  assert_r0_storage_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    regs[0] == '0);

  // A write to a nonzero entry is read back on the next cycle.
  assert_write_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(we) && ($past(wa) != '0) && (ra1 == $past(wa)))
      |-> (rd1 == $past(wd)));
endmodule

// File: rtl/scpu_alu.sv
module scpu_alu
  import scpu_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  always_comb begin
    unique case (op)
      ALU_SUB:   y = a - b;
      ALU_SLT:   y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_AND:   y = a & b;
      ALU_OR:    y = a | b;
      ALU_PASSB: y = b;
      default:   y = a + b;
    endcase
  end
endmodule

// File: rtl/scpu_nextpc.sv
module scpu_nextpc
  import scpu_pkg::*;
(
  input  logic [XLEN-1:0] pc,
  input  logic            hold,
  input  logic            br_eq,
  input  logic            br_ne,
  input  logic            jump,
  input  logic            operands_equal,
  input  logic [15:0]     offset,
  input  logic [25:0]     jidx,
  output logic [XLEN-1:0] pc_next
);
  logic [XLEN-1:0] pc4;
  logic [XLEN-1:0] br_target;
  logic [XLEN-1:0] j_target;
  logic            taken;

  assign pc4       = pc + 32'd4;
  assign br_target = pc4 + {{14{offset[15]}}, offset, 2'b00};
  assign j_target  = {pc4[31:28], jidx, 2'b00};
  assign taken     = (br_eq && operands_equal) || (br_ne && !operands_equal);

  always_comb begin
    if (hold)       pc_next = pc;
    else if (jump)  pc_next = j_target;
    else if (taken) pc_next = br_target;
    else            pc_next = pc4;
  end
endmodule

// File: rtl/scpu_core.sv
module scpu_core
  import scpu_pkg::*;
#(
  parameter int IMEM_AW = 8,
  parameter int DMEM_AW = 8,
  localparam int LOAD_AW = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_en,
  input  logic               ld_dmem,
  input  logic [LOAD_AW-1:0] ld_addr,
  input  logic [31:0]        ld_data,
  output logic [31:0]        pc_o,
  output logic               wb_en,
  output logic [4:0]         wb_reg,
  output logic [31:0]        wb_data,
  output logic               st_en,
  output logic [31:0]        st_addr,
  output logic [31:0]        st_data
);
  localparam int IMEM_WORDS = 1 << IMEM_AW;
  localparam int DMEM_WORDS = 1 << DMEM_AW;

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0]   pc, pc_next, instr;
  ctrl_t             ctl;
  logic [REG_AW-1:0] rs, rt, rd, dst;
  logic [15:0]       imm16;
  logic [XLEN-1:0]   imm_ext, rs_val, rt_val, alu_b, alu_y, load_val;
  logic [25:0]       jidx;

  assign instr = imem[pc[IMEM_AW+1:2]];

  scpu_decode u_decode (
    .instr(instr), .ctl(ctl), .rs(rs), .rt(rt), .rd(rd),
    .imm16(imm16), .imm_ext(imm_ext), .jidx(jidx)
  );

  assign dst   = ctl.dst_rd ? rd : rt;
  assign wb_en = ctl.reg_write && !ld_en && (dst != '0);

  scpu_regfile u_regfile (
    .clk(clk), .rst_n(rst_n), .we(wb_en), .wa(dst), .wd(wb_data),
    .ra1(rs), .ra2(rt), .rd1(rs_val), .rd2(rt_val)
  );

  assign alu_b = ctl.use_imm ? imm_ext : rt_val;

  scpu_alu u_alu (.op(ctl.alu_op), .a(rs_val), .b(alu_b), .y(alu_y));

  assign load_val = dmem[alu_y[DMEM_AW+1:2]];
  assign wb_data  = ctl.mem_read ? load_val : alu_y;
  assign wb_reg   = dst;
  assign st_en    = ctl.mem_write && !ld_en;
  assign st_addr  = alu_y;
  assign st_data  = rt_val;

  scpu_nextpc u_nextpc (
    .pc(pc), .hold(ld_en), .br_eq(ctl.br_eq), .br_ne(ctl.br_ne), .jump(ctl.jump),
    .operands_equal(rs_val == rt_val), .offset(imm16), .jidx(jidx), .pc_next(pc_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_next;
  end
  assign pc_o = pc;

  always_ff @(posedge clk) begin
    if (ld_en && !ld_dmem) imem[ld_addr[IMEM_AW-1:0]] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (ld_en && ld_dmem)  dmem[ld_addr[DMEM_AW-1:0]] <= ld_data;
    else if (st_en)        dmem[st_addr[DMEM_AW+1:2]] <= st_data;
  end

  assert_pc_word_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc[1:0] == 2'b00);

  assert_load_freezes_pc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> $stable(pc));

  assert_load_blocks_writes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |-> (!wb_en && !st_en));

  assert_plain_advance_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !ctl.br_eq && !ctl.br_ne && !ctl.jump) |=> (pc == $past(pc) + 32'd4));

  assert_compare_is_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && (ctl.alu_op == ALU_SLT)) |-> (wb_data[31:1] == '0));
endmodule

// File: tb/scpu_core_bench.sv
`timescale 1ns/1ps
module scpu_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic        ld_dmem = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] pc_o, wb_data, st_addr, st_data;
  logic        wb_en, st_en;
  logic [4:0]  wb_reg;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_imem [256];
  logic [31:0] m_dmem [256];
  logic [31:0] m_reg  [32];
  logic [31:0] m_pc;

  always #2 clk = ~clk;

  scpu_core u_scpu_core (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_dmem(ld_dmem),
    .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o), .wb_en(wb_en),
    .wb_reg(wb_reg), .wb_data(wb_data), .st_en(st_en),
    .st_addr(st_addr), .st_data(st_data)
  );

  function automatic logic [31:0] enc_r(logic [5:0] fn, logic [4:0] d, logic [4:0] s, logic [4:0] t);
    return {6'd0, s, t, d, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] t, logic [4:0] s, logic [15:0] imm);
    return {op, s, t, imm};
  endfunction
  function automatic logic [31:0] enc_j(logic [25:0] idx);
    return {6'd2, idx};
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Instruction-level reference: predict this cycle's outputs, compare, then commit.
  task automatic step_check();
    logic [31:0] ins, a, b, imm_s, imm_z, res, addr, pc4, nxt;
    logic [5:0]  op, fn;
    logic [4:0]  s, t, d, sh, dst;
    logic        wr, st;
    string       tag;
    ins = m_imem[m_pc[9:2]];
    op = ins[31:26]; s = ins[25:21]; t = ins[20:16]; d = ins[15:11];
    sh = ins[10:6]; fn = ins[5:0];
    a = m_reg[s]; b = m_reg[t];
    imm_s = {{16{ins[15]}}, ins[15:0]};
    imm_z = {16'h0, ins[15:0]};
    pc4 = m_pc + 4; nxt = pc4;
    wr = 1'b0; st = 1'b0; res = '0; addr = '0; dst = t; tag = "R10";
    case (op)
      6'd0: if (sh == 0) begin
        dst = d;
        case (fn)
          6'd32: begin wr = 1; res = a + b; tag = "R2"; end
          6'd34: begin wr = 1; res = a - b; tag = "R2"; end
          6'd42: begin wr = 1; res = {31'd0, $signed(a) < $signed(b)}; tag = "R5"; end
          default: ;
        endcase
      end
      6'd8:  begin wr = 1; res = a + imm_s; tag = "R3"; end
      6'd10: begin wr = 1; res = {31'd0, $signed(a) < $signed(imm_s)}; tag = "R5"; end
      6'd12: begin wr = 1; res = a & imm_z; tag = "R3"; end
      6'd13: begin wr = 1; res = a | imm_z; tag = "R3"; end
      6'd15: begin wr = 1; res = {ins[15:0], 16'h0}; tag = "R4"; end
      6'd35: begin addr = a + imm_s; wr = 1; res = m_dmem[addr[9:2]]; tag = (addr[1:0] != 0) ? "R12" : "R6"; end
      6'd43: begin addr = a + imm_s; st = 1; tag = (addr[1:0] != 0) ? "R12" : "R6"; end
      6'd4:  begin tag = "R7"; if (a == b) nxt = pc4 + {imm_s[29:0], 2'b00}; end
      6'd5:  begin tag = "R7"; if (a != b) nxt = pc4 + {imm_s[29:0], 2'b00}; end
      6'd2:  begin tag = "R8"; nxt = {pc4[31:28], ins[25:0], 2'b00}; end
      default: ;
    endcase
    if (wr && dst == 0) begin wr = 0; tag = "R9"; end
    check(tag, "pc", pc_o, m_pc);
    check(tag, "wb_en", {31'd0, wb_en}, {31'd0, wr});
    if (wr) begin
      check(tag, "wb_reg", {27'd0, wb_reg}, {27'd0, dst});
      check(tag, "wb_data", wb_data, res);
    end
    check(tag, "st_en", {31'd0, st_en}, {31'd0, st});
    if (st) begin
      check(tag, "st_addr", st_addr, addr);
      check(tag, "st_data", st_data, b);
      m_dmem[addr[9:2]] = b;
    end
    if (wr) m_reg[dst] = res;
    m_pc = nxt;
  endtask

  task automatic load_and_run(int nwords, int cycles);
    rst_n = 0; ld_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1; ld_en = 1; ld_dmem = 1;
    #1 check("R1", "pc after reset", pc_o, 32'd0);
    for (int i = 0; i < 256; i++) begin
      ld_addr = i[7:0]; ld_data = m_dmem[i];
      @(negedge clk);
    end
    ld_dmem = 0;
    for (int i = 0; i < nwords; i++) begin
      ld_addr = i[7:0]; ld_data = m_imem[i];
      @(negedge clk);
      #1;
      check("R11", "pc held", pc_o, 32'd0);
      check("R11", "writes blocked", {30'd0, wb_en, st_en}, 32'd0);
    end
    ld_en = 0;
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    m_pc = '0;
    for (int c = 0; c < cycles; c++) begin
      #1 step_check();
      @(negedge clk);
    end
  endtask

  function automatic logic [31:0] rand_instr(int idx, int n);
    logic [4:0]  s, t, d;
    logic [15:0] imm, off;
    int lim;
    s = 5'($urandom % 8); t = 5'($urandom % 8); d = 5'($urandom % 8);
    imm = 16'($urandom);
    off = 16'(($urandom % 64) * 4 + ((($urandom % 4) == 0) ? ($urandom % 4) : 0));
    lim = (n - idx < 4) ? (n - idx) : 4;
    case ($urandom % 13)
      0:  return enc_r(6'd32, d, s, t);
      1:  return enc_r(6'd34, d, s, t);
      2:  return enc_r(6'd42, d, s, t);
      3:  return enc_i(6'd8, t, s, imm);
      4:  return enc_i(6'd10, t, s, imm);
      5:  return enc_i(6'd12, t, s, imm);
      6:  return enc_i(6'd13, t, s, imm);
      7:  return enc_i(6'd15, t, s, imm);
      8:  return enc_i(6'd35, t, 5'd0, off);
      9:  return enc_i(6'd43, t, ($urandom % 2) ? 5'd0 : s, off);
      10: return enc_i(6'd4, t, s, 16'($urandom % lim));
      11: return enc_i(6'd5, t, s, 16'($urandom % lim));
      default: return ($urandom % 2) ? {6'd63, 26'($urandom)} : (enc_r(6'd32, d, s, t) | 32'h40);
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin m_dmem[i] = $urandom; m_imem[i] = '0; end
    m_dmem[255] = 32'h1234_5678;
    // Directed corner program.
    m_imem[0]  = enc_i(6'd15, 5'd1, 5'd0, 16'hAAAA);      // R4 lui
    m_imem[1]  = enc_i(6'd13, 5'd1, 5'd1, 16'h5555);      // R4 ori fills low half
    m_imem[2]  = enc_i(6'd8,  5'd2, 5'd0, 16'hFFFD);      // R3 addi -3
    m_imem[3]  = enc_i(6'd12, 5'd3, 5'd1, 16'hFFFF);      // R3 andi zero-extends
    m_imem[4]  = enc_r(6'd42, 5'd4, 5'd2, 5'd0);          // R5 -3 < 0
    m_imem[5]  = enc_i(6'd10, 5'd5, 5'd0, 16'hFFFF);      // R5 0 < -1 is false
    m_imem[6]  = enc_r(6'd34, 5'd6, 5'd0, 5'd2);          // R2 sub
    m_imem[7]  = enc_i(6'd8,  5'd0, 5'd1, 16'd5);         // R9 write to r0 dropped
    m_imem[8]  = enc_r(6'd32, 5'd7, 5'd0, 5'd0);          // R9 r0 reads zero
    m_imem[9]  = enc_i(6'd43, 5'd1, 5'd0, 16'd8);         // R6 sw
    m_imem[10] = enc_i(6'd35, 5'd8, 5'd0, 16'd10);        // R12 low bits ignored
    m_imem[11] = 32'hFC00_0000;                           // R10 undefined op
    m_imem[12] = enc_i(6'd4, 5'd0, 5'd7, 16'd1);          // R7 beq taken
    m_imem[13] = enc_i(6'd8, 5'd9, 5'd0, 16'd1);
    m_imem[14] = enc_i(6'd5, 5'd0, 5'd7, 16'd5);          // R7 bne not taken
    m_imem[15] = enc_i(6'd35, 5'd10, 5'd6, 16'hFFFC);     // R6 negative offset wraps
    m_imem[16] = enc_j(26'd18);                           // R8 jump
    m_imem[17] = enc_i(6'd8, 5'd11, 5'd0, 16'd1);
    m_imem[18] = enc_r(6'd32, 5'd12, 5'd1, 5'd2) | 32'h0000_0080; // R10 shamt set
    m_imem[19] = enc_i(6'd4, 5'd0, 5'd0, 16'hFFFF);       // R7 backward self-loop
    load_and_run(20, 30);
    // Second run of the same program: registers must restart from zero (R1).
    load_and_run(20, 12);
    // Random programs ending in a jump to self.
    for (int run = 0; run < 4; run++) begin
      for (int i = 0; i < 256; i++) m_dmem[i] = $urandom;
      for (int i = 0; i < 48; i++) m_imem[i] = rand_instr(i, 48);
      m_imem[48] = enc_j(26'd48);
      load_and_run(49, 90);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule